// File: doc/BRIEF.md
# Direct-Store Bus Cycle Sequencer

This block sequences the bus activity of one 8-bit processor instruction that stores a 16-bit register pair to a memory address given inside the instruction. A start request taken while the block is idle begins an opcode fetch at the program counter. Two operand reads follow and return the low and the high byte of the target address. Two write cycles then store the low register byte at the target address and the high register byte at the next address.

Every clock is one T-state. The block drives a 16-bit address bus, an 8-bit write data bus, and read and write strobes. It reports the current machine-cycle number and T-state number so that a bus monitor can follow the sequence. A ready input held low during T2 stretches a cycle with wait states. When the last cycle ends, a one-clock done pulse appears together with the program counter value that follows the instruction.

Top module: `hl_store_seq`

## Requirements
- R1: After reset the block is idle: `mcycle` = 0, `tstate` = 0, and `rd`, `wr` and `done` are all low.
- R2: A `start` seen high at a clock edge while idle makes the next clock machine cycle 1, T-state 1. Machine cycle 1 runs T-states 1,2,3,4. Machine cycles 2, 3, 4 and 5 each run T-states 1,2,3. With `ready` high this gives 16 T-states in total. `mcycle` is reported as 1..5 and `tstate` as 1..4.
- R3: Machine cycles 1, 2 and 3 place the program counter, the program counter + 1 and the program counter + 2 on `addr`, each sum taken modulo 2^16. The `din` value at the end of T3 of cycle 2 is taken as the target low byte, and at the end of T3 of cycle 3 as the target high byte.
- R4: `rd` is high exactly in T2 and T3 (wait states included) of cycles 1 to 3. `wr` is high exactly in T2 and T3 of cycles 4 and 5. Both strobes are low in T1 and T4, and they are never high together.
- R5: `addr` holds one value for every T-state of a machine cycle.
- R6: Cycle 4 drives the latched low register byte on `dout` at address {high,low}. Cycle 5 drives the latched high register byte at {high,low} + 1, which wraps from 0xFFFF to 0x0000. Each value is held for the whole cycle.
- R7: `done` is high for exactly the one clock after T3 of cycle 5, with `mcycle` = 0. In that clock `pc_next` equals the start program counter + 3 modulo 2^16.
- R8: `ready` is looked at only in T2. When it is low there, T2 repeats with the address and strobe unchanged. These wait states do not change the T-state numbering, and each one adds one clock.
- R9: `start` is ignored while an instruction is in progress.
- R10: `pc_in`, `reg_l` and `reg_h` are sampled only when a start is accepted. Changing them later has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the instruction when idle |
| ready | input | 1 | Low in T2 inserts a wait state |
| pc_in | input | 16 | Address of the opcode |
| reg_l | input | 8 | Low register byte to store |
| reg_h | input | 8 | High register byte to store |
| din | input | 8 | Read data from memory |
| addr | output | 16 | Address bus |
| dout | output | 8 | Write data bus |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| mcycle | output | 3 | Machine-cycle number, 0 when idle |
| tstate | output | 3 | T-state number, 0 when idle |
| done | output | 1 | One-clock end-of-instruction pulse |
| pc_next | output | 16 | Program counter after the instruction |

## Verification
The sweep crosses five program counter values with four target addresses and with zero, one or two wait states in every T2. The program counter values sit near and at 0xFFFF, so the three operand fetch addresses are seen wrapping. The targets 0x00FF and 0xFFFF separate a full 16-bit increment of the second write address from an 8-bit one and from a missing wrap. The wait-state counts separate waits that hold T2 from waits that advance the T-state number. `ready` is driven low outside T2, which shows that it is looked at only in T2. `start` is held high, and the latched inputs are inverted after acceptance, which exposes any restart or late sampling.

// File: rtl/hls_pkg.sv
package hls_pkg;
  localparam int unsigned MC_W    = 3;
  localparam int unsigned TS_W    = 3;
  localparam int unsigned PC_STEP = 3;

  typedef enum logic [MC_W-1:0] {
    MC_IDLE  = 3'd0,
    MC_FETCH = 3'd1,
    MC_ADLO  = 3'd2,
    MC_ADHI  = 3'd3,
    MC_WRLO  = 3'd4,
    MC_WRHI  = 3'd5
  } mcyc_e;

  typedef enum logic [TS_W-1:0] {
    TS_NONE = 3'd0,
    TS_1    = 3'd1,
    TS_2    = 3'd2,
    TS_3    = 3'd3,
    TS_4    = 3'd4
  } tst_e;

  function automatic mcyc_e next_mc(input mcyc_e m);
    case (m)
      MC_FETCH: next_mc = MC_ADLO;
      MC_ADLO:  next_mc = MC_ADHI;
      MC_ADHI:  next_mc = MC_WRLO;
      MC_WRLO:  next_mc = MC_WRHI;
      default:  next_mc = MC_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/hls_timing.sv
module hls_timing
  import hls_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  ready,
  output mcyc_e mcyc,
  output tst_e  tst,
  output logic  accept,
  output logic  done
);
  assign accept = (tst == TS_NONE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcyc <= MC_IDLE;
      tst  <= TS_NONE;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (tst)
        TS_NONE: if (start) begin
          mcyc <= MC_FETCH;
          tst  <= TS_1;
        end
        TS_1: tst <= TS_2;
        TS_2: if (ready) tst <= TS_3;
        TS_3: begin
          if (mcyc == MC_FETCH) begin
            tst <= TS_4;
          end else if (mcyc == MC_WRHI) begin
            mcyc <= MC_IDLE;
            tst  <= TS_NONE;
            done <= 1'b1;
          end else begin
            mcyc <= next_mc(mcyc);
            tst  <= TS_1;
          end
        end
        TS_4: begin
          mcyc <= next_mc(mcyc);
          tst  <= TS_1;
        end
        default: begin
          mcyc <= MC_IDLE;
          tst  <= TS_NONE;
        end
      endcase
    end
  end

  AST_IDLE_PAIRING: assert property (@(posedge clk) disable iff (rst)
    (mcyc == MC_IDLE) == (tst == TS_NONE)); // R2
  AST_T4_FETCH_ONLY: assert property (@(posedge clk) disable iff (rst)
    (tst == TS_4) |-> (mcyc == MC_FETCH)); // R2
  AST_WAIT_HOLDS_T2: assert property (@(posedge clk) disable iff (rst)
    (tst == TS_2 && !ready) |=> (tst == TS_2 && $stable(mcyc))); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (mcyc == MC_WRHI && tst == TS_3) |=> done); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (mcyc != MC_IDLE) |=> !(mcyc == MC_FETCH && tst == TS_1)); // R9
endmodule

// File: rtl/hls_addr_path.sv
module hls_addr_path
  import hls_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] l_in,
  input  logic [DW-1:0] h_in,
  input  logic [DW-1:0] din,
  input  mcyc_e         mcyc,
  input  tst_e          tst,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic [AW-1:0] pc_next
);
  localparam int unsigned TB = AW / 2;
  localparam logic [AW-1:0] ONE  = AW'(1);
  localparam logic [AW-1:0] TWO  = AW'(2);
  localparam logic [AW-1:0] STEP = AW'(PC_STEP);

  logic [AW-1:0] pc_q;
  logic [DW-1:0] l_q, h_q;
  logic [TB-1:0] tlo_q, thi_q;
  logic [AW-1:0] tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      l_q     <= '0;
      h_q     <= '0;
      tlo_q   <= '0;
      thi_q   <= '0;
      pc_next <= '0;
    end else begin
      if (load) begin
        pc_q    <= pc_in;
        l_q     <= l_in;
        h_q     <= h_in;
        pc_next <= pc_in + STEP;
      end
      if (mcyc == MC_ADLO && tst == TS_3) tlo_q <= din[TB-1:0];
      if (mcyc == MC_ADHI && tst == TS_3) thi_q <= din[TB-1:0];
    end
  end

  assign tgt = {thi_q, tlo_q};

  always_comb begin
    case (mcyc)
      MC_FETCH: addr = pc_q;
      MC_ADLO:  addr = pc_q + ONE;
      MC_ADHI:  addr = pc_q + TWO;
      MC_WRLO:  addr = tgt;
      MC_WRHI:  addr = tgt + ONE;
      default:  addr = '0;
    endcase
    case (mcyc)
      MC_WRLO: wdata = l_q;
      MC_WRHI: wdata = h_q;
      default: wdata = '0;
    endcase
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mcyc != MC_IDLE && tst != TS_1) |-> $stable(addr)); // R5
  AST_SECOND_WRITE_STEP: assert property (@(posedge clk) disable iff (rst)
    (mcyc == MC_WRHI && tst == TS_1) |-> (addr == AW'($past(addr) + ONE))); // R6
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((mcyc == MC_WRLO || mcyc == MC_WRHI) && tst != TS_1) |-> $stable(wdata)); // R6
endmodule

// File: rtl/hls_strobe.sv
module hls_strobe
  import hls_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mcyc_e mcyc,
  input  tst_e  tst,
  output logic  rd,
  output logic  wr
);
  logic active;
  logic is_read;

  always_comb begin
    active  = (tst == TS_2) || (tst == TS_3);
    is_read = (mcyc == MC_FETCH) || (mcyc == MC_ADLO) || (mcyc == MC_ADHI);
    rd = active && is_read;
    wr = active && (mcyc == MC_WRLO || mcyc == MC_WRHI);
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd && wr)); // R4
  AST_RD_RISE_T2: assert property (@(posedge clk) disable iff (rst)
    $rose(rd) |-> (tst == TS_2)); // R4
  AST_WR_RISE_T2: assert property (@(posedge clk) disable iff (rst)
    $rose(wr) |-> (tst == TS_2)); // R4
endmodule

// File: rtl/hl_store_seq.sv
module hl_store_seq
  import hls_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ready,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] reg_l,
  input  logic [DW-1:0] reg_h,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  output logic          rd,
  output logic          wr,
  output logic [2:0]    mcycle,
  output logic [2:0]    tstate,
  output logic          done,
  output logic [AW-1:0] pc_next
);
  mcyc_e mcyc;
  tst_e  tst;
  logic  accept;

  hls_timing u_timing (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .ready  (ready),
    .mcyc   (mcyc),
    .tst    (tst),
    .accept (accept),
    .done   (done)
  );

  hls_addr_path #(.AW(AW), .DW(DW)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .pc_in   (pc_in),
    .l_in    (reg_l),
    .h_in    (reg_h),
    .din     (din),
    .mcyc    (mcyc),
    .tst     (tst),
    .addr    (addr),
    .wdata   (dout),
    .pc_next (pc_next)
  );

  hls_strobe u_strobe (
    .clk  (clk),
    .rst  (rst),
    .mcyc (mcyc),
    .tst  (tst),
    .rd   (rd),
    .wr   (wr)
  );

  assign mcycle = mcyc;
  assign tstate = tst;

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (mcycle == 3'd0 && !rd && !wr)); // R7
endmodule

// File: tb/tb_hl_store_seq.sv
module tb_hl_store_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst, start, ready;
  logic [AW-1:0] pc_in;
  logic [DW-1:0] reg_l, reg_h, din;
  logic [AW-1:0] addr, pc_next;
  logic [DW-1:0] dout;
  logic          rd, wr, done;
  logic [2:0]    mcycle, tstate;

  int n_chk = 0;
  int n_bad = 0;

  logic [AW-1:0] cur_pc;
  logic [DW-1:0] cur_lo, cur_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  hl_store_seq #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .start(start), .ready(ready),
    .pc_in(pc_in), .reg_l(reg_l), .reg_h(reg_h), .din(din),
    .addr(addr), .dout(dout), .rd(rd), .wr(wr),
    .mcycle(mcycle), .tstate(tstate), .done(done), .pc_next(pc_next)
  );

  // simple memory: opcode at pc, target bytes at pc+1 and pc+2
  always_comb begin
    if (addr == cur_pc + 16'd1)      din = cur_lo;
    else if (addr == cur_pc + 16'd2) din = cur_hi;
    else                             din = 8'h22;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [15:0] pc, input logic [7:0] l, input logic [7:0] h,
                         input logic [15:0] tgt, input int waits);
    int e_seq = 0, e_rda = 0, e_str = 0, e_wr = 0, n_ts = 0, n_clk = 0;
    logic [15:0] ea;
    cur_pc = pc; cur_lo = tgt[7:0]; cur_hi = tgt[15:8];
    pc_in = pc; reg_l = l; reg_h = h; start = 1'b1; ready = 1'b1;
    @(posedge clk); @(negedge clk);
    pc_in = ~pc; reg_l = ~l; reg_h = ~h;   // R10: late changes must be ignored
    for (int mc = 1; mc <= 5; mc++) begin
      int nt = (mc == 1) ? 4 : 3;
      case (mc)
        1: ea = pc;
        2: ea = pc + 16'd1;
        3: ea = pc + 16'd2;
        4: ea = tgt;
        default: ea = tgt + 16'd1;
      endcase
      for (int ts = 1; ts <= nt; ts++) begin
        int nw = (ts == 2) ? waits : 0;
        for (int w = 0; w <= nw; w++) begin
          bit e_rd, e_wrs;
          if (mc == 5) start = 1'b0;
          if (mcycle != 3'(mc) || tstate != 3'(ts)) e_seq++;
          e_rd  = (mc <= 3) && (ts == 2 || ts == 3);
          e_wrs = (mc >= 4) && (ts == 2 || ts == 3);
          if (rd != e_rd || wr != e_wrs) e_str++;
          if (mc <= 3 && addr != ea) e_rda++;
          if (mc >= 4 && (addr != ea || dout != ((mc == 4) ? l : h))) e_wr++;
          if (w == 0) n_ts++;
          n_clk++;
          ready = (ts == 2) ? (w == nw) : 1'b0;
          @(negedge clk);
        end
      end
    end
    ready = 1'b1;
    chk(e_seq == 0 && n_ts == 16, "R2 cycle/T-state order", e_seq, 0);
    chk(e_rda == 0, "R3 operand fetch addresses", e_rda, 0);
    chk(e_str == 0, "R4 strobe timing", e_str, 0);
    chk(e_wr == 0, "R6/R10/R5 write address and data", e_wr, 0);
    chk(n_clk == 16 + 5 * waits, "R8 wait-state clocks", n_clk, 16 + 5 * waits);
    chk(done == 1'b1 && mcycle == 3'd0, "R7 done pulse", done, 1);
    chk(pc_next == pc + 16'd3, "R7 pc_next", pc_next, pc + 16'd3);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single clock", done, 0);
    chk(mcycle == 3'd0, "R9 no restart while busy", mcycle, 0);
  endtask

  initial begin
    logic [15:0] pcs [5];
    logic [15:0] tgts [4];
    pcs[0] = 16'h0000; pcs[1] = 16'h1234; pcs[2] = 16'hFFFD;
    pcs[3] = 16'hFFFE; pcs[4] = 16'hFFFF;
    tgts[0] = 16'h0000; tgts[1] = 16'h00FF; tgts[2] = 16'hFFFF; tgts[3] = 16'hABCD;
    cur_pc = 16'h0; cur_lo = 8'h0; cur_hi = 8'h0;
    rst = 1'b1; start = 1'b0; ready = 1'b1;
    pc_in = '0; reg_l = '0; reg_h = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mcycle == 3'd0, "R1 idle mcycle", mcycle, 0);
    chk(tstate == 3'd0, "R1 idle tstate", tstate, 0);
    chk(!rd && !wr, "R1 strobes low", {rd, wr}, 0);
    chk(!done, "R1 done low", done, 0);
    for (int p = 0; p < 5; p++)
      for (int t = 0; t < 4; t++)
        for (int w = 0; w < 3; w++)
          run_one(pcs[p], 8'h5A ^ 8'(p * 17 + t), 8'hC3 ^ 8'(t * 29 + w), tgts[t], w);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule